// File: doc/BRIEF.md
# Strap-Configured Host Control Port

This block gives an external processor a byte-wide control channel into an internal core. One set of shared pins serves as configuration straps while reset is held. The port then behaves as one of three host buses: a parallel bus with separate read and write strobes, a parallel bus with a direction line and a single data strobe, or a four-wire serial link. The mode is captured from three strap pins at the moment reset is released. It stays fixed until the next reset.

Four byte registers are visible to the host. The data register is the window onto two small queues. Host reads take bytes from the core's outgoing queue, and host writes feed the core's incoming queue. A status register reports the state of the queues, and two scratch registers hold any value the host writes. The core side uses valid/ready handshakes on both queues. An open-drain style pull-down enable tells the host that outgoing bytes are waiting.

Top module: `hostport_top`

## Requirements
- R1: `mode_q` loads from straps {host_ms2_i, host_ms1, host_ms0} on every clock while `rst` is high, and holds after release. {ms1,ms0}=00 selects serial mode. Any other value selects parallel mode: strobe-pair signalling when ms2=0, direction/strobe signalling when ms2=1. Later pin activity never changes the mode.
- R2: While `rst` is high, `host_d_oe`, `host_ms2_oe` and `irq_n_oe` are all 0.
- R3: Strobe-pair mode. With `host_cs_n` low and read strobe `host_ms1` low, the bus drives the register at address {host_a1_sdi, host_a0}. A write takes effect once, at the rising edge of write strobe `host_ms0` while `host_cs_n` is low, and it stores `host_d_i`.
- R4: Direction/strobe mode. `host_ms1` high means read and low means write. `host_ms0` is an active-low data strobe. The bus is driven while the strobe is low with the direction set to read, and a write takes effect at the strobe's rising edge.
- R5: Address 0 read returns the oldest outgoing byte (0 when the queue is empty) and removes it at the end of the access. Address 0 write appends to the incoming queue and is dropped when that queue is full. Address 1 reads {6'b0, incoming full, outgoing non-empty} and ignores writes. Addresses 2 and 3 are scratch registers that reset to 0.
- R6: Serial mode uses SPI mode 0, MSB first. Clock is `host_sclk`, data in is `host_a1_sdi`, and data out is `host_ms2_o`. The first byte is a command (bit7=1 read, bits1:0 address) and the second byte is the data. `host_ms2_oe` is high only while `host_cs_n` is low in serial mode.
- R7: In serial mode, raising `host_cs_n` before the sixteenth clock leaves all registers and queues untouched.
- R8: After reset, `irq_n_oe` is 1 exactly when the outgoing queue holds at least one byte.
- R9: `core_out_ready` is high while the outgoing queue has room, and each queue holds DEPTH bytes (default 4). `core_in_valid` is high while the incoming queue is non-empty, and a byte leaves it only when `core_in_ready` is high.
- R10: The data bus is never driven in serial mode, and `host_ms2_oe` is never high in the parallel modes.
- R11: In the parallel modes, strobes given while `host_cs_n` is high neither drive the bus nor change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; its release latches the straps |
| host_cs_n | input | 1 | Active-low select, all modes |
| host_a0 | input | 1 | Register address bit 0 (parallel) |
| host_a1_sdi | input | 1 | Address bit 1 (parallel) or serial data in |
| host_ms1 | input | 1 | Strap bit 1; read strobe or read/write direction |
| host_ms0 | input | 1 | Strap bit 0; write strobe or data strobe |
| host_ms2_i | input | 1 | Strap bit 2 input |
| host_ms2_o | output | 1 | Serial data out |
| host_ms2_oe | output | 1 | Output enable for the strap-2 pin |
| host_sclk | input | 1 | Serial clock |
| host_d_i | input | 8 | Parallel data bus in |
| host_d_o | output | 8 | Parallel data bus out |
| host_d_oe | output | 1 | Parallel data bus output enable |
| irq_n_oe | output | 1 | Pull-down enable for the active-low interrupt line |
| core_out_data | input | 8 | Byte from the core to the host |
| core_out_valid | input | 1 | Core offers a byte |
| core_out_ready | output | 1 | Outgoing queue accepts it |
| core_in_data | output | 8 | Oldest byte written by the host |
| core_in_valid | output | 1 | Incoming queue non-empty |
| core_in_ready | input | 1 | Core takes the byte |

## Verification
The bench resets into each of the three modes. In each mode it sweeps the scratch registers over all byte values, or over a spread of values in serial mode, and predicts every read from its own queue and register model. A port that samples the straps at the wrong time, or keeps re-sampling them, fails the check that gives an old-style read after the strap pin has moved. A port that acts on the leading strobe edge, or acts twice per strobe, shows up as lost or duplicated queue bytes in the fill/drain runs at exactly DEPTH and DEPTH+1 entries. A serial port that shifts one edge early or late returns rotated scratch values, and one that commits on an aborted frame overwrites a scratch register. Writes to status, strobes without select, and strobes in serial mode must all leave the bus undriven and the readback unchanged.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    localparam logic [AW-1:0] ADDR_DATA = 2'd0;
    localparam logic [AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [AW-1:0] ADDR_SCR0 = 2'd2;
    localparam logic [AW-1:0] ADDR_SCR1 = 2'd3;

    typedef enum logic [1:0] {
        MODE_PAIR   = 2'd0,
        MODE_DIRSTB = 2'd1,
        MODE_SER    = 2'd2
    } port_mode_e;

    // One register access, produced by either front end.
    typedef struct packed {
        logic          valid;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } host_acc_t;

    typedef struct packed {
        logic          cs_n;
        logic [AW-1:0] a;
        logic          s1;
        logic          s0;
        logic [DW-1:0] d;
    } par_pins_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
    } ser_pins_t;

    localparam par_pins_t PAR_IDLE = '{cs_n: 1'b1, a: '0, s1: 1'b1, s0: 1'b1, d: '0};
    localparam ser_pins_t SER_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

    function automatic port_mode_e strap_decode(input logic [2:0] s);
        if (s[1:0] == 2'b00) return MODE_SER;
        else if (s[2])       return MODE_DIRSTB;
        else                 return MODE_PAIR;
    endfunction

endpackage

// File: rtl/hp_fifo.sv
module hp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/hp_par_front.sv
module hp_par_front
    import hp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          dir_mode,
    input  par_pins_t     pins,
    output host_acc_t     acc
);
    par_pins_t meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= PAR_IDLE;
            sync_q <= PAR_IDLE;
            prev_q <= PAR_IDLE;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    logic s0_rise, s1_rise;
    assign s0_rise = !prev_q.s0 && sync_q.s0 && !prev_q.cs_n;
    assign s1_rise = !prev_q.s1 && sync_q.s1 && !prev_q.cs_n;

    // Access fires on the trailing edge of the strobe, address and data
    // taken from the last synchronised sample before that edge.
    always_comb begin
        acc = '0;
        if (en) begin
            if (!dir_mode) begin
                if (s0_rise)
                    acc = '{valid: 1'b1, write: 1'b1, addr: prev_q.a, wdata: prev_q.d};
                else if (s1_rise)
                    acc = '{valid: 1'b1, write: 1'b0, addr: prev_q.a, wdata: '0};
            end else if (s0_rise) begin
                acc = '{valid: 1'b1, write: !prev_q.s1, addr: prev_q.a, wdata: prev_q.d};
            end
        end
    end
endmodule

// File: rtl/hp_ser_front.sv
module hp_ser_front
    import hp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  ser_pins_t     pins,
    output logic [AW-1:0] peek_addr,
    input  logic [DW-1:0] peek_data,
    output logic          sdo,
    output host_acc_t     acc
);
    localparam int FRAME = 2 * DW;
    localparam int CW    = $clog2(FRAME) + 1;

    ser_pins_t     meta_q, sync_q, prev_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rx_q, tx_q;
    logic          cmd_rd_q;
    logic [AW-1:0] cmd_addr_q;
    logic          rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= SER_IDLE;
            sync_q <= SER_IDLE;
            prev_q <= SER_IDLE;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise      = en && !sync_q.cs_n && sync_q.sclk && !prev_q.sclk;
    assign fall      = en && !sync_q.cs_n && !sync_q.sclk && prev_q.sclk;
    assign peek_addr = {rx_q[0], sync_q.sdi};
    assign sdo       = tx_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst || !en || sync_q.cs_n) begin
            cnt_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            cmd_rd_q   <= 1'b0;
            cmd_addr_q <= '0;
        end else begin
            if (rise) begin
                rx_q <= {rx_q[DW-2:0], sync_q.sdi};
                if (cnt_q != CW'(FRAME)) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(DW - 1)) begin
                    cmd_rd_q   <= rx_q[DW-2];
                    cmd_addr_q <= peek_addr;
                    tx_q       <= rx_q[DW-2] ? peek_data : '0;
                end
            end
            if (fall && cnt_q > CW'(DW) && cnt_q < CW'(FRAME))
                tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end

    always_comb begin
        acc = '0;
        if (rise && cnt_q == CW'(FRAME - 1))
            acc = '{valid: 1'b1, write: !cmd_rd_q, addr: cmd_addr_q,
                    wdata: {rx_q[DW-2:0], sync_q.sdi}};
    end
endmodule

// File: rtl/hostport_top.sv
module hostport_top
    import hp_pkg::*;
#(
    parameter int OUT_DEPTH = 4,
    parameter int IN_DEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cs_n,
    input  logic          host_a0,
    input  logic          host_a1_sdi,
    input  logic          host_ms1,
    input  logic          host_ms0,
    input  logic          host_ms2_i,
    output logic          host_ms2_o,
    output logic          host_ms2_oe,
    input  logic          host_sclk,
    input  logic [DW-1:0] host_d_i,
    output logic [DW-1:0] host_d_o,
    output logic          host_d_oe,
    output logic          irq_n_oe,
    input  logic [DW-1:0] core_out_data,
    input  logic          core_out_valid,
    output logic          core_out_ready,
    output logic [DW-1:0] core_in_data,
    output logic          core_in_valid,
    input  logic          core_in_ready
);
    localparam int NREG = 1 << AW;
    localparam int NSCR = NREG - 2;

    port_mode_e    mode_q;
    logic          is_par;
    host_acc_t     par_acc, ser_acc, acc;
    logic [DW-1:0] reg_view [NREG];
    logic [DW-1:0] scr_q [NSCR];
    logic [AW-1:0] ser_peek_addr;
    logic          ser_sdo;
    logic [DW-1:0] out_head;
    logic          out_empty, out_full, in_empty, in_full;
    par_pins_t     par_pins;
    ser_pins_t     ser_pins;

    // Straps follow the pins throughout reset; the last value stays.
    always_ff @(posedge clk) begin
        if (rst) mode_q <= strap_decode({host_ms2_i, host_ms1, host_ms0});
    end

    assign is_par   = (mode_q != MODE_SER);
    assign par_pins = '{cs_n: host_cs_n, a: {host_a1_sdi, host_a0},
                        s1: host_ms1, s0: host_ms0, d: host_d_i};
    assign ser_pins = '{cs_n: host_cs_n, sclk: host_sclk, sdi: host_a1_sdi};

    hp_par_front u_par (
        .clk      (clk),
        .rst      (rst),
        .en       (is_par),
        .dir_mode (mode_q == MODE_DIRSTB),
        .pins     (par_pins),
        .acc      (par_acc)
    );

    hp_ser_front u_ser (
        .clk       (clk),
        .rst       (rst),
        .en        (!is_par),
        .pins      (ser_pins),
        .peek_addr (ser_peek_addr),
        .peek_data (reg_view[ser_peek_addr]),
        .sdo       (ser_sdo),
        .acc       (ser_acc)
    );

    assign acc = is_par ? par_acc : ser_acc;

    hp_fifo #(.WIDTH(DW), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk   (clk),
        .rst   (rst),
        .push  (core_out_valid),
        .wdata (core_out_data),
        .pop   (acc.valid && !acc.write && acc.addr == ADDR_DATA),
        .head  (out_head),
        .empty (out_empty),
        .full  (out_full)
    );

    hp_fifo #(.WIDTH(DW), .DEPTH(IN_DEPTH)) u_in_q (
        .clk   (clk),
        .rst   (rst),
        .push  (acc.valid && acc.write && acc.addr == ADDR_DATA),
        .wdata (acc.wdata),
        .pop   (core_in_ready),
        .head  (core_in_data),
        .empty (in_empty),
        .full  (in_full)
    );

    assign core_out_ready = !out_full;
    assign core_in_valid  = !in_empty;

    generate
        for (genvar g = 0; g < NSCR; g++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst)
                    scr_q[g] <= '0;
                else if (acc.valid && acc.write && acc.addr == AW'(g + 2))
                    scr_q[g] <= acc.wdata;
            end
            assign reg_view[g + 2] = scr_q[g];
        end
    endgenerate

    assign reg_view[ADDR_DATA] = out_empty ? '0 : out_head;
    assign reg_view[ADDR_STAT] = {{(DW - 2){1'b0}}, in_full, !out_empty};

    assign host_d_o  = reg_view[{host_a1_sdi, host_a0}];
    assign host_d_oe = !rst && is_par && !host_cs_n &&
                       ((mode_q == MODE_PAIR) ? !host_ms1 : (host_ms1 && !host_ms0));

    assign host_ms2_o  = ser_sdo;
    assign host_ms2_oe = !rst && !is_par && !host_cs_n;
    assign irq_n_oe    = !rst && !out_empty;
endmodule

// File: rtl/hp_checker.sv
module hp_checker
    import hp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_cs_n,
    input logic       host_d_oe,
    input logic       host_ms2_oe,
    input logic       irq_n_oe,
    input logic       core_out_valid,
    input logic       core_out_ready,
    input logic       core_in_valid,
    input logic       core_in_ready,
    input port_mode_e mode_q
);
    always @(posedge clk) begin
        if (rst) begin
            a_r2_quiet_in_reset: assert (!host_d_oe && !host_ms2_oe && !irq_n_oe)
                else $error("R2: pin driven during reset");
        end
    end

    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));

    a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
        !(host_d_oe && host_ms2_oe));

    a_r6_sdo_needs_cs: assert property (@(posedge clk) disable iff (rst)
        host_ms2_oe |-> !host_cs_n);

    a_r11_bus_needs_cs: assert property (@(posedge clk) disable iff (rst)
        host_d_oe |-> !host_cs_n);

    a_r8_irq_after_push: assert property (@(posedge clk) disable iff (rst)
        (core_out_valid && core_out_ready) |=> irq_n_oe);

    a_r9_in_holds: assert property (@(posedge clk) disable iff (rst)
        (core_in_valid && !core_in_ready) |=> core_in_valid);
endmodule

bind hostport_top hp_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .host_cs_n      (host_cs_n),
    .host_d_oe      (host_d_oe),
    .host_ms2_oe    (host_ms2_oe),
    .irq_n_oe       (irq_n_oe),
    .core_out_valid (core_out_valid),
    .core_out_ready (core_out_ready),
    .core_in_valid  (core_in_valid),
    .core_in_ready  (core_in_ready),
    .mode_q         (mode_q)
);

// File: tb/hostport_top_tb_top.sv
`timescale 1ns/1ps
module hostport_top_tb_top;
    localparam int QD = 4;
    localparam int M_PAIR = 0, M_DIR = 1, M_SER = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_a1_sdi = 1'b0;
    logic       host_ms1 = 1'b1, host_ms0 = 1'b1, host_ms2_i = 1'b0;
    logic       host_ms2_o, host_ms2_oe, host_sclk = 1'b0;
    logic [7:0] host_d_i = '0, host_d_o;
    logic       host_d_oe, irq_n_oe;
    logic [7:0] core_out_data = '0, core_in_data;
    logic       core_out_valid = 1'b0, core_out_ready, core_in_valid, core_in_ready = 1'b0;

    always #10 clk = ~clk;

    hostport_top dut_i (.*);

    int n_checks = 0, n_fail = 0;
    int cur_mode = 0;
    logic [7:0] out_m[$], in_m[$];
    logic [7:0] scr_m [4];
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (mode %0d)", req, act, exp, cur_mode);
        end
    endtask

    function automatic string mode_req();
        return (cur_mode == M_PAIR) ? "R3" : (cur_mode == M_DIR) ? "R4" : "R6";
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int m);
        @(negedge clk);
        rst = 1'b1; host_cs_n = 1'b1; host_sclk = 1'b0;
        case (m)
            M_PAIR:  {host_ms2_i, host_ms1, host_ms0} = 3'b011;
            M_DIR:   {host_ms2_i, host_ms1, host_ms0} = 3'b111;
            default: {host_ms2_i, host_ms1, host_ms0} = 3'b000;
        endcase
        tick(3);
        chk("R2 d_oe", host_d_oe, 0);
        chk("R2 ms2_oe", host_ms2_oe, 0);
        chk("R2 irq", irq_n_oe, 0);
        rst = 1'b0;
        tick(1);
        host_ms1 = 1'b1; host_ms0 = 1'b1; host_ms2_i = 1'b0;
        tick(2);
        cur_mode = m;
        out_m.delete(); in_m.delete();
        foreach (scr_m[i]) scr_m[i] = '0;
    endtask

    task automatic par_write(input logic [1:0] a, input logic [7:0] v, input bit sel);
        host_a1_sdi = a[1]; host_a0 = a[0]; host_d_i = v;
        if (cur_mode == M_DIR) host_ms1 = 1'b0;
        host_cs_n = !sel;
        tick(2);
        host_ms0 = 1'b0;
        tick(3);
        host_ms0 = 1'b1;
        tick(4);
        host_cs_n = 1'b1; host_ms1 = 1'b1;
        tick(2);
    endtask

    task automatic par_read(input logic [1:0] a, output logic [7:0] v);
        host_a1_sdi = a[1]; host_a0 = a[0]; host_ms1 = 1'b1;
        host_cs_n = 1'b0;
        tick(1);
        if (cur_mode == M_PAIR) host_ms1 = 1'b0; else host_ms0 = 1'b0;
        tick(3);
        v = host_d_o;
        chk({mode_req(), " bus driven on read"}, host_d_oe, 1);
        host_ms1 = 1'b1; host_ms0 = 1'b1;
        tick(4);
        host_cs_n = 1'b1;
        tick(2);
    endtask

    task automatic ser_xfer(input logic [7:0] cmd, input logic [7:0] wd,
                            input int nbits, output logic [7:0] rd);
        logic [15:0] frame;
        frame = {cmd, wd};
        rd = '0;
        host_cs_n = 1'b0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            host_a1_sdi = frame[15 - i];
            tick(8);
            if (i >= 8) rd[15 - i] = host_ms2_o;
            host_sclk = 1'b1;
            tick(8);
            host_sclk = 1'b0;
        end
        tick(6);
        host_cs_n = 1'b1;
        tick(6);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] v);
        logic [7:0] dummy;
        if (cur_mode == M_SER) ser_xfer({6'b0, a}, v, 16, dummy);
        else par_write(a, v, 1'b1);
        if (a >= 2) scr_m[a] = v;
        else if (a == 0 && in_m.size() < QD) in_m.push_back(v);
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] v, output logic [7:0] exp);
        if (cur_mode == M_SER) ser_xfer({6'b100000, a}, 8'h00, 16, v);
        else par_read(a, v);
        case (a)
            2'd0: exp = (out_m.size() == 0) ? 8'h00 : out_m.pop_front();
            2'd1: exp = {6'b0, in_m.size() == QD, out_m.size() != 0};
            default: exp = scr_m[a];
        endcase
    endtask

    task automatic core_push(input logic [7:0] v);
        core_out_data = v; core_out_valid = 1'b1;
        chk("R9 out_ready", core_out_ready, out_m.size() < QD);
        if (core_out_ready) out_m.push_back(v);
        tick(1);
        core_out_valid = 1'b0;
        tick(1);
    endtask

    task automatic core_pop();
        chk("R9 in_valid", core_in_valid, in_m.size() != 0);
        if (core_in_valid) begin
            chk("R9 in_data order", core_in_data, in_m.pop_front());
            core_in_ready = 1'b1;
            tick(1);
            core_in_ready = 1'b0;
        end
        tick(1);
    endtask

    task automatic run_mode(input int m);
        logic [7:0] got, exp;
        int n;
        do_reset(m);
        host_read(2'd1, got, exp); chk("R5 status after reset", got, exp);
        host_read(2'd2, got, exp); chk("R5 scratch reset", got, exp);

        n = (m == M_SER) ? 32 : 256;
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = (m == M_SER) ? 8'((k * 37 + 5) ^ (k << 3)) : 8'(k);
            host_write(2'd2, v);
            host_write(2'd3, ~v);
            host_read(2'd2, got, exp); chk({mode_req(), " scratch2"}, got, exp);
            host_read(2'd3, got, exp); chk({mode_req(), " scratch3"}, got, exp);
        end

        // Outgoing queue: fill past depth, then drain past empty
        for (int k = 0; k < QD + 1; k++) core_push(8'hA0 + 8'(k));
        chk("R8 irq with data", irq_n_oe, 1);
        host_read(2'd1, got, exp); chk("R5 status out avail", got, exp);
        for (int k = 0; k < QD + 1; k++) begin
            host_read(2'd0, got, exp); chk("R5 data read order", got, exp);
        end
        chk("R8 irq cleared", irq_n_oe, 0);

        // Incoming queue: fill past depth
        for (int k = 0; k < QD + 1; k++) host_write(2'd0, 8'h10 + 8'(k));
        host_read(2'd1, got, exp); chk("R5 status in full", got, exp);
        host_write(2'd1, 8'hFF);
        host_read(2'd1, got, exp); chk("R5 status write ignored", got, exp);
        for (int k = 0; k < QD + 1; k++) core_pop();
        host_read(2'd1, got, exp); chk("R5 status drained", got, exp);

        if (m == M_SER) begin
            // Aborted frame must not commit
            ser_xfer(8'h02, 8'h5A, 12, got);
            host_read(2'd2, got, exp); chk("R7 abort keeps scratch", got, exp);
            ser_xfer(8'h00, 8'h77, 15, got);
            chk("R7 abort keeps in queue", core_in_valid, 0);
            // Parallel strobes are dead in serial mode
            host_cs_n = 1'b0; host_ms1 = 1'b0; host_ms0 = 1'b0;
            tick(3);
            chk("R10 no bus in serial", host_d_oe, 0);
            host_ms0 = 1'b1; host_ms1 = 1'b1;
            tick(4);
            host_cs_n = 1'b1;
            tick(2);
            host_read(2'd2, got, exp); chk("R1 still serial after pin moves", got, exp);
        end else begin
            host_cs_n = 1'b0;
            tick(2);
            chk("R10 no sdo in parallel", host_ms2_oe, 0);
            host_cs_n = 1'b1;
            tick(1);
            // Strobes without select
            par_write(2'd2, ~scr_m[2], 1'b0);
            host_a1_sdi = 1'b1; host_a0 = 1'b0;
            if (m == M_PAIR) host_ms1 = 1'b0; else host_ms0 = 1'b0;
            tick(3);
            chk("R11 no drive without cs", host_d_oe, 0);
            host_ms1 = 1'b1; host_ms0 = 1'b1;
            tick(3);
            host_read(2'd2, got, exp); chk("R11 write without cs ignored", got, exp);
            // Strap pin moves after release: mode must not follow
            host_ms2_i = ~host_ms2_i;
            host_ms1 = 1'b1; host_ms0 = 1'b1;
            tick(3);
            host_cs_n = 1'b0;
            if (m == M_PAIR) host_ms1 = 1'b0; else host_ms0 = 1'b0;
            tick(3);
            chk("R1 mode held after strap change", host_d_oe, 1);
            host_ms1 = 1'b1; host_ms0 = 1'b1;
            tick(4);
            host_cs_n = 1'b1;
            tick(2);
            host_ms2_i = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        run_mode(M_PAIR);
        run_mode(M_DIR);
        run_mode(M_SER);
        run_mode(M_PAIR);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule